// File: doc/BRIEF.md
# Capability-Bounded Memory Access Unit

This unit forms the address of a memory access made through a capability and decides whether the access may proceed. The capability is presented as its lower bound, its exclusive upper bound (65 bits wide, so that the bound can reach 2^64), its current cursor and a permission that allows tagged capabilities to be loaded. An index register value and a signed immediate are added to the cursor, with the immediate scaled by the size of the access. The full byte range of the access is then compared with the bounds. A range that falls outside raises a length fault. A range that lies inside issues a single memory request, and translation is the identity.

Load responses are widened to 64 bits by sign or zero extension according to the access width. A capability load returns the full 128-bit image, with a validity tag that survives only if memory supplied it, the permission allows it and the response does not ask for it to be suppressed. Linked loads open a reservation that holds a flag and the address. A conditional store goes to memory only while the reservation is open, and every attempt closes the reservation. The unit has one access outstanding at a time.

Top module: `cap_access_unit`

## Requirements
- R1: A data access issues `mem_addr` = cursor + index + (imm sign-extended) × size. `op_width` gives the size: 0 = 1, 1 = 2, 2 = 4, 3 = 8 bytes. `mem_size` carries the byte count. The request appears one cycle after `op_valid`.
- R2: With `op_cap` = 1 the access is 16 bytes, the immediate is scaled by 16, and `mem_size` = 16.
- R3: If address < base or address + size > top, `fault_len` pulses one cycle after `op_valid` and no request or store-conditional result is produced. An access ending exactly at top, or starting exactly at base, is allowed.
- R4: Address arithmetic is carried out in more than 65 bits. An access whose end passes 2^64 faults even when the bound is 2^64, and the sum is never wrapped back to a low address.
- R5: One cycle after `mem_rvalid`, a data load returns on `rsp_data` the low 1/2/4/8 bytes of `mem_rdata`. These are sign-extended to 64 bits when `op_signext` was 1 and zero-extended otherwise. Bits above 64 are zero and `rsp_tag` is 0.
- R6: A load with `op_linked` = 1 that does not fault sets `ll_flag` and loads `ll_addr` with its address, both visible in the cycle of the request.
- R7: A store with `op_linked` = 1 is conditional. When `ll_flag` is clear it makes no request and pulses `sc_done` with `sc_ok` = 0 one cycle after `op_valid`. When `ll_flag` is set it issues a request with `mem_cond` = 1, and `sc_done`/`sc_ok` follow `mem_sc_ok` one cycle after `mem_rvalid`.
- R8: A data store writes on `mem_wdata` the low 1/2/4/8 bytes of `src_data`, zero above, with `mem_wtag` = 0. A capability store writes all 128 bits of `src_data` with `mem_wtag` = `src_tag`.
- R9: Every conditional store that does not fault leaves `ll_flag` clear, whether or not it reached memory.
- R10: A capability load returns `rsp_tag` = `mem_rtag` AND the `cap_ld_perm` captured at issue AND NOT `mem_rsupp`.
- R11: After reset, `mem_req`, `fault_len`, `busy`, `rsp_valid`, `sc_done` and `ll_flag` are 0.
- R12: While `busy` is high, meaning a load or a memory-bound conditional store awaits `mem_rvalid`, `op_valid` is ignored and produces neither a request nor a fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Access command present |
| op_store | input | 1 | 1 = store, 0 = load |
| op_cap | input | 1 | Capability-sized (16-byte) access |
| op_width | input | 2 | Data size code, 0..3 = 1, 2, 4, 8 bytes |
| op_signext | input | 1 | Sign-extend load data |
| op_linked | input | 1 | Linked load / conditional store |
| cap_base | input | AW | Capability lower bound |
| cap_top | input | AW+1 | Capability exclusive upper bound |
| cap_cursor | input | AW | Capability cursor (base + offset) |
| cap_ld_perm | input | 1 | Permission to load tagged capabilities |
| idx_val | input | AW | Index register value, unsigned |
| imm | input | IMM_W | Signed immediate |
| src_data | input | CAP_W | Store source |
| src_tag | input | 1 | Tag of the store source |
| mem_req | output | 1 | Memory request pulse |
| mem_we | output | 1 | Request is a write |
| mem_cond | output | 1 | Request is a conditional write |
| mem_addr | output | AW | Request address |
| mem_size | output | log2(CAP_W/8)+1 | Request size in bytes |
| mem_wdata | output | CAP_W | Write data |
| mem_wtag | output | 1 | Write tag |
| mem_rvalid | input | 1 | Response for the outstanding access |
| mem_rdata | input | CAP_W | Read data |
| mem_rtag | input | 1 | Tag read from memory |
| mem_rsupp | input | 1 | Suppress the tag of this read |
| mem_sc_ok | input | 1 | Conditional write succeeded |
| fault_len | output | 1 | Length violation pulse |
| busy | output | 1 | Waiting for a response |
| rsp_valid | output | 1 | Load result valid |
| rsp_data | output | CAP_W | Load result |
| rsp_tag | output | 1 | Load result tag |
| sc_done | output | 1 | Conditional store finished |
| sc_ok | output | 1 | Conditional store result |
| ll_flag | output | 1 | Reservation open |
| ll_addr | output | AW | Reservation address |

## Verification
The address path is driven with positive and negative immediates at every data size and at capability size. This separates a correct scaling of the immediate from a missing or wrong shift. The bounds check is probed at both bounds: one byte inside and one byte outside of each, and with a cursor just below 2^64, where only arithmetic wide enough to hold the carry separates a fault from a wrapped in-bounds address. Load responses carry a set sign bit and non-zero upper bytes, so that extension and masking faults show. Capability loads cycle through tag, permission and suppression one at a time. The reservation is exercised through a sequence of failing, succeeding and repeated conditional stores around a linked load.

// File: rtl/cap_access_unit.sv
module cap_access_unit #(
  parameter int AW    = 64,
  parameter int IMM_W = 8,
  parameter int CAP_W = 128
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         op_valid,
  input  logic                         op_store,
  input  logic                         op_cap,
  input  logic [1:0]                   op_width,
  input  logic                         op_signext,
  input  logic                         op_linked,
  input  logic [AW-1:0]                cap_base,
  input  logic [AW:0]                  cap_top,
  input  logic [AW-1:0]                cap_cursor,
  input  logic                         cap_ld_perm,
  input  logic [AW-1:0]                idx_val,
  input  logic [IMM_W-1:0]             imm,
  input  logic [CAP_W-1:0]             src_data,
  input  logic                         src_tag,
  output logic                         mem_req,
  output logic                         mem_we,
  output logic                         mem_cond,
  output logic [AW-1:0]                mem_addr,
  output logic [$clog2(CAP_W/8):0]     mem_size,
  output logic [CAP_W-1:0]             mem_wdata,
  output logic                         mem_wtag,
  input  logic                         mem_rvalid,
  input  logic [CAP_W-1:0]             mem_rdata,
  input  logic                         mem_rtag,
  input  logic                         mem_rsupp,
  input  logic                         mem_sc_ok,
  output logic                         fault_len,
  output logic                         busy,
  output logic                         rsp_valid,
  output logic [CAP_W-1:0]             rsp_data,
  output logic                         rsp_tag,
  output logic                         sc_done,
  output logic                         sc_ok,
  output logic                         ll_flag,
  output logic [AW-1:0]                ll_addr
);

  localparam int CAP_SH = $clog2(CAP_W/8);
  localparam int SZW    = CAP_SH + 1;
  localparam int XW     = AW + 3;

  logic [2:0]             sh;
  logic [SZW-1:0]         sz;
  logic signed [XW-1:0]   imm_x, off_x, va, end_x, base_x, top_x;
  logic                   out_of_range, accept, is_cs;
  logic [CAP_W-1:0]       wdata;
  logic [AW-1:0]          dext;

  logic                   pend, p_cap, p_sx, p_perm, p_cs;
  logic [1:0]             p_w;

  assign sh     = op_cap ? 3'(CAP_SH) : {1'b0, op_width};
  assign sz     = SZW'(1) << sh;
  assign imm_x  = XW'($signed(imm));
  assign off_x  = imm_x <<< sh;
  assign va     = $signed({3'b000, cap_cursor}) + $signed({3'b000, idx_val}) + off_x;
  assign end_x  = va + $signed(XW'(sz));
  assign base_x = $signed({3'b000, cap_base});
  assign top_x  = $signed({2'b00, cap_top});
  assign out_of_range = (va < base_x) || (end_x > top_x);

  assign accept = op_valid && !pend;
  assign is_cs  = op_store && op_linked;
  assign busy   = pend;

  always_comb begin
    case (op_width)
      2'd0:    wdata = CAP_W'(src_data[7:0]);
      2'd1:    wdata = CAP_W'(src_data[15:0]);
      2'd2:    wdata = CAP_W'(src_data[31:0]);
      default: wdata = CAP_W'(src_data[AW-1:0]);
    endcase
    if (op_cap) wdata = src_data;
  end

  always_comb begin
    case (p_w)
      2'd0:    dext = p_sx ? AW'($signed(mem_rdata[7:0]))  : AW'(mem_rdata[7:0]);
      2'd1:    dext = p_sx ? AW'($signed(mem_rdata[15:0])) : AW'(mem_rdata[15:0]);
      2'd2:    dext = p_sx ? AW'($signed(mem_rdata[31:0])) : AW'(mem_rdata[31:0]);
      default: dext = mem_rdata[AW-1:0];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_cond  <= 1'b0;
      mem_addr  <= '0;
      mem_size  <= '0;
      mem_wdata <= '0;
      mem_wtag  <= 1'b0;
      fault_len <= 1'b0;
      pend      <= 1'b0;
      p_cap     <= 1'b0;
      p_sx      <= 1'b0;
      p_perm    <= 1'b0;
      p_cs      <= 1'b0;
      p_w       <= 2'd0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      rsp_tag   <= 1'b0;
      sc_done   <= 1'b0;
      sc_ok     <= 1'b0;
      ll_flag   <= 1'b0;
      ll_addr   <= '0;
    end else begin
      mem_req   <= 1'b0;
      fault_len <= 1'b0;
      sc_done   <= 1'b0;
      rsp_valid <= 1'b0;
      if (accept) begin
        if (out_of_range) begin
          fault_len <= 1'b1;
        end else if (is_cs && !ll_flag) begin
          sc_done <= 1'b1;
          sc_ok   <= 1'b0;
        end else begin
          mem_req   <= 1'b1;
          mem_we    <= op_store;
          mem_cond  <= is_cs;
          mem_addr  <= va[AW-1:0];
          mem_size  <= sz;
          mem_wdata <= op_store ? wdata : '0;
          mem_wtag  <= op_store && op_cap && src_tag;
          pend      <= !op_store || is_cs;
          p_cap     <= op_cap;
          p_sx      <= op_signext;
          p_perm    <= cap_ld_perm;
          p_cs      <= is_cs;
          p_w       <= op_width;
          if (!op_store && op_linked) begin
            ll_flag <= 1'b1;
            ll_addr <= va[AW-1:0];
          end
          if (is_cs) ll_flag <= 1'b0;
        end
      end
      if (pend && mem_rvalid) begin
        pend <= 1'b0;
        if (p_cs) begin
          sc_done <= 1'b1;
          sc_ok   <= mem_sc_ok;
        end else begin
          rsp_valid <= 1'b1;
          rsp_data  <= p_cap ? mem_rdata : CAP_W'(dext);
          rsp_tag   <= p_cap && mem_rtag && p_perm && !mem_rsupp;
        end
      end
    end
  end

  p_fault_blocks_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fault_len |-> !mem_req && !sc_done);

  p_cond_needs_link_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_cond) |-> $past(ll_flag));

  p_link_closed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_cond) |-> !ll_flag);

  p_data_write_untagged_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && !mem_size[SZW-1]) |-> !mem_wtag);

  p_rsp_after_mem_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(mem_rvalid));

  p_link_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we && $rose(ll_flag)) |-> ll_addr == mem_addr);

  p_ignore_when_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !mem_rvalid) |=> !mem_req && !fault_len);

endmodule

// File: tb/cap_access_unit_test.sv
module cap_access_unit_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic         op_valid = 0, op_store = 0, op_cap = 0, op_signext = 0, op_linked = 0;
  logic [1:0]   op_width = 0;
  logic [63:0]  cap_base = 0, cap_cursor = 0, idx_val = 0;
  logic [64:0]  cap_top = 0;
  logic         cap_ld_perm = 0;
  logic [7:0]   imm = 0;
  logic [127:0] src_data = 0;
  logic         src_tag = 0;
  logic         mem_rvalid = 0, mem_rtag = 0, mem_rsupp = 0, mem_sc_ok = 0;
  logic [127:0] mem_rdata = 0;

  logic         mem_req, mem_we, mem_cond, mem_wtag, fault_len, busy;
  logic [63:0]  mem_addr, ll_addr;
  logic [4:0]   mem_size;
  logic [127:0] mem_wdata, rsp_data;
  logic         rsp_valid, rsp_tag, sc_done, sc_ok, ll_flag;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  cap_access_unit uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_store(op_store), .op_cap(op_cap),
    .op_width(op_width), .op_signext(op_signext), .op_linked(op_linked),
    .cap_base(cap_base), .cap_top(cap_top), .cap_cursor(cap_cursor), .cap_ld_perm(cap_ld_perm),
    .idx_val(idx_val), .imm(imm), .src_data(src_data), .src_tag(src_tag),
    .mem_req(mem_req), .mem_we(mem_we), .mem_cond(mem_cond), .mem_addr(mem_addr),
    .mem_size(mem_size), .mem_wdata(mem_wdata), .mem_wtag(mem_wtag),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .mem_rtag(mem_rtag),
    .mem_rsupp(mem_rsupp), .mem_sc_ok(mem_sc_ok), .fault_len(fault_len), .busy(busy),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_tag(rsp_tag), .sc_done(sc_done),
    .sc_ok(sc_ok), .ll_flag(ll_flag), .ll_addr(ll_addr)
  );

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_cap(input logic [63:0] b, input logic [64:0] t, input logic [63:0] c,
                         input logic perm);
    cap_base = b; cap_top = t; cap_cursor = c; cap_ld_perm = perm;
  endtask

  // drives one command for one cycle; outputs are valid at return
  task automatic issue(input logic st, input logic cp, input logic [1:0] w, input logic sx,
                       input logic lk, input logic [63:0] idx, input logic [7:0] im);
    @(negedge clk);
    op_valid = 1; op_store = st; op_cap = cp; op_width = w; op_signext = sx;
    op_linked = lk; idx_val = idx; imm = im;
    @(negedge clk);
    op_valid = 0;
  endtask

  task automatic respond(input logic [127:0] d, input logic t, input logic s, input logic ok);
    mem_rvalid = 1; mem_rdata = d; mem_rtag = t; mem_rsupp = s; mem_sc_ok = ok;
    @(negedge clk);
    mem_rvalid = 0;
  endtask

  task automatic t_reset;
    chk("R11 mem_req", 128'(mem_req), 0);
    chk("R11 fault_len", 128'(fault_len), 0);
    chk("R11 busy", 128'(busy), 0);
    chk("R11 rsp_valid", 128'(rsp_valid), 0);
    chk("R11 sc_done", 128'(sc_done), 0);
    chk("R11 ll_flag", 128'(ll_flag), 0);
  endtask

  task automatic t_data_addr;
    set_cap(64'h1000, 65'h2000, 64'h1100, 1);
    src_data = 128'h1111_2222_3333_4444_5555_6666_7777_8888; src_tag = 1;
    issue(1, 0, 2'd2, 0, 0, 64'h20, -8'sd3);
    chk("R1 store addr", 128'(mem_addr), 128'h1114);
    chk("R1 store size", 128'(mem_size), 4);
    chk("R1 store req", 128'({mem_req, mem_we, busy}), 128'b110);
    chk("R8 data wdata", mem_wdata, 128'h7777_8888);
    chk("R8 data wtag", 128'(mem_wtag), 0);
    issue(1, 0, 2'd0, 0, 0, 64'h0, -8'sd1);
    chk("R1 byte store addr", 128'(mem_addr), 128'h10FF);
    chk("R8 byte wdata", mem_wdata, 128'h88);
    issue(0, 0, 2'd3, 1, 0, 64'h20, 8'sd5);
    chk("R1 load addr", 128'(mem_addr), 128'h1148);
    chk("R1 load size/busy", 128'({mem_size, busy}), 128'({5'd8, 1'b1}));
    respond(128'hDEAD_0000_0000_BEEF_FEDC_BA98_7654_3210, 1, 0, 0);
    chk("R5 dword load", rsp_data, 128'hFEDC_BA98_7654_3210);
    chk("R5 data tag zero", 128'({rsp_valid, rsp_tag, busy}), 128'b100);
  endtask

  task automatic t_cap;
    set_cap(64'h1000, 65'h2000, 64'h1100, 1);
    issue(0, 1, 2'd0, 0, 0, 64'h0, 8'sd2);
    chk("R2 cap addr", 128'(mem_addr), 128'h1120);
    chk("R2 cap size", 128'(mem_size), 16);
    respond(128'hCAFE_F00D_0123_4567_89AB_CDEF_0011_2233, 1, 0, 0);
    chk("R10 cap data", rsp_data, 128'hCAFE_F00D_0123_4567_89AB_CDEF_0011_2233);
    chk("R10 tag kept", 128'(rsp_tag), 1);
    set_cap(64'h1000, 65'h2000, 64'h1100, 0);
    issue(0, 1, 2'd0, 0, 0, 64'h0, -8'sd1);
    chk("R2 cap negative imm", 128'(mem_addr), 128'h10F0);
    cap_ld_perm = 1;
    respond(128'h5, 1, 0, 0);
    chk("R10 no permission", 128'(rsp_tag), 0);
    issue(0, 1, 2'd0, 0, 0, 64'h0, 8'sd0);
    respond(128'h5, 1, 1, 0);
    chk("R10 suppressed", 128'(rsp_tag), 0);
    issue(0, 1, 2'd0, 0, 0, 64'h0, 8'sd0);
    respond(128'h5, 0, 0, 0);
    chk("R10 memory untagged", 128'(rsp_tag), 0);
    src_data = 128'hA5A5_0000_1111_2222_3333_4444_5555_6666; src_tag = 1;
    issue(1, 1, 2'd0, 0, 0, 64'h0, 8'sd1);
    chk("R8 cap store", mem_wdata, 128'hA5A5_0000_1111_2222_3333_4444_5555_6666);
    chk("R8 cap store tag/addr", 128'({mem_wtag, mem_addr}), 128'({1'b1, 64'h1110}));
  endtask

  task automatic t_bounds;
    set_cap(64'h1000, 65'h2000, 64'h1FF8, 1);
    issue(1, 0, 2'd3, 0, 0, 64'h0, 8'sd0);
    chk("R3 end at top allowed", 128'({mem_req, fault_len}), 128'b10);
    cap_cursor = 64'h1FF9;
    issue(1, 0, 2'd3, 0, 0, 64'h0, 8'sd0);
    chk("R3 one past top", 128'({mem_req, fault_len}), 128'b01);
    cap_cursor = 64'h1000;
    issue(0, 0, 2'd0, 0, 0, 64'h0, -8'sd1);
    chk("R3 below base", 128'({mem_req, fault_len, busy}), 128'b010);
    issue(0, 0, 2'd0, 0, 0, 64'h0, 8'sd0);
    chk("R3 at base allowed", 128'({mem_req, fault_len}), 128'b10);
    respond(128'h0, 0, 0, 0);
  endtask

  task automatic t_wide;
    set_cap(64'h0, 65'h1_0000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFC, 1);
    issue(1, 0, 2'd3, 0, 0, 64'h0, 8'sd0);
    chk("R4 end past 2^64", 128'({mem_req, fault_len}), 128'b01);
    issue(1, 0, 2'd2, 0, 0, 64'h0, 8'sd0);
    chk("R4 end at 2^64", 128'({mem_req, fault_len, mem_addr}), {62'd0, 2'b10, 64'hFFFF_FFFF_FFFF_FFFC});
    cap_cursor = 64'hFFFF_FFFF_FFFF_FFF0;
    issue(1, 0, 2'd0, 0, 0, 64'h20, 8'sd0);
    chk("R4 no wrap", 128'({mem_req, fault_len}), 128'b01);
  endtask

  task automatic t_extend;
    set_cap(64'h1000, 65'h2000, 64'h1100, 1);
    issue(0, 0, 2'd0, 1, 0, 64'h0, 8'sd0);
    respond(128'hAAAA_AAAA_AAAA_AAAA_AAAA_AAAA_AAAA_AA80, 0, 0, 0);
    chk("R5 byte sign", rsp_data, 128'hFFFF_FFFF_FFFF_FF80);
    issue(0, 0, 2'd0, 0, 0, 64'h0, 8'sd0);
    respond(128'hAAAA_AAAA_AAAA_AAAA_AAAA_AAAA_AAAA_AA80, 0, 0, 0);
    chk("R5 byte zero", rsp_data, 128'h80);
    issue(0, 0, 2'd1, 1, 0, 64'h0, 8'sd0);
    respond(128'hAAAA_AAAA_AAAA_AAAA_AAAA_AAAA_AAAA_8001, 0, 0, 0);
    chk("R5 half sign", rsp_data, 128'hFFFF_FFFF_FFFF_8001);
    issue(0, 0, 2'd2, 0, 0, 64'h0, 8'sd0);
    respond(128'hAAAA_AAAA_AAAA_AAAA_AAAA_AAAA_8000_0000, 0, 0, 0);
    chk("R5 word zero", rsp_data, 128'h8000_0000);
    issue(0, 0, 2'd2, 1, 0, 64'h0, 8'sd0);
    respond(128'h0000_0000_0000_0000_0000_0000_7FFF_FFFF, 0, 0, 0);
    chk("R5 word positive sign", rsp_data, 128'h7FFF_FFFF);
  endtask

  task automatic t_link;
    set_cap(64'h1000, 65'h2000, 64'h1100, 1);
    src_data = 128'h0000_0000_0000_0000_0000_0000_0000_ABCD; src_tag = 1;
    issue(1, 0, 2'd1, 0, 1, 64'h0, 8'sd0);
    chk("R7 no reservation", 128'({mem_req, sc_done, sc_ok}), 128'b010);
    issue(0, 0, 2'd3, 0, 1, 64'h8, 8'sd1);
    chk("R6 flag set", 128'(ll_flag), 1);
    chk("R6 reservation addr", 128'(ll_addr), 128'h1110);
    respond(128'h0, 0, 0, 0);
    issue(1, 0, 2'd1, 0, 1, 64'h0, 8'sd0);
    chk("R7 attempt issued", 128'({mem_req, mem_we, mem_cond, busy}), 128'b1111);
    chk("R8 conditional wdata", mem_wdata, 128'hABCD);
    chk("R9 flag cleared", 128'(ll_flag), 0);
    respond(128'h0, 0, 0, 1);
    chk("R7 success reported", 128'({sc_done, sc_ok}), 128'b11);
    issue(1, 0, 2'd1, 0, 1, 64'h0, 8'sd0);
    chk("R9 second attempt fails", 128'({mem_req, sc_done, sc_ok}), 128'b010);
    issue(0, 0, 2'd2, 0, 1, 64'h0, 8'sd0);
    respond(128'h0, 0, 0, 0);
    issue(1, 0, 2'd2, 0, 1, 64'h0, 8'sd0);
    respond(128'h0, 0, 0, 0);
    chk("R7 memory refusal", 128'({sc_done, sc_ok, ll_flag}), 128'b100);
  endtask

  task automatic t_busy;
    set_cap(64'h1000, 65'h2000, 64'h1100, 1);
    issue(0, 0, 2'd3, 0, 0, 64'h0, 8'sd0);
    chk("R12 busy raised", 128'(busy), 1);
    cap_cursor = 64'h3000;
    issue(1, 0, 2'd3, 0, 0, 64'h0, 8'sd0);
    chk("R12 ignored op", 128'({mem_req, fault_len, busy}), 128'b001);
    respond(128'h1234, 0, 0, 0);
    chk("R12 original load completes", 128'({rsp_valid, rsp_data[15:0]}), 128'({1'b1, 16'h1234}));
    chk("R12 busy cleared", 128'(busy), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_link();
    t_data_addr();
    t_cap();
    t_bounds();
    t_wide();
    t_extend();
    t_busy();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule